// File: doc/BRIEF.md
# Controller Pad Capture and Response Packer

This block takes a controller input word written by a host agent in a fast host clock domain and makes it usable in the slower core clock domain. The word is held in a host-side register and carried across the domain boundary by a chain of synchronizing flops. The two lowest bytes of the word are then turned into the two active-low digital button bytes that a game controller reports. The bits are also reordered on the way. The resulting button bytes are always visible on a pad-state output.

When core logic asks for a report, the block takes a snapshot of the button bytes. It builds a 16-byte controller response record from a fixed header, the two button bytes and neutral analog values. The record leaves as four 32-bit beats on a valid/ready stream, and the final beat is flagged.

Top module: `pad_capture_packer`

## Requirements
- R1: After reset, `pad_state` reads 0x0000FFFF and `out_valid` is low; both synchronizer stages reset to zero, which means no buttons are pressed.
- R2: A host write (`host_wr_en` high on an `hclk` edge) is captured into the host register and reaches `pad_state` after passing through two `cclk` flops; the new value is visible within four `cclk` cycles of the write.
- R3: Button bytes are active low: with no input bit set, both button bytes read 0xFF.
- R4: Input bit 0 (right) clears bit 5 of button byte 0, so right alone gives 0xDF. Input bit 5 (select) clears bit 0 of button byte 0, so right plus select gives 0xDE.
- R5: Each remaining input bit clears one bit of a button byte. Bits 1 (left), 2 (down), 3 (up), 4 (start), 6 (L3) and 7 (R3) clear byte-0 bits 7, 6, 4, 3, 1 and 2. Bits 8 (cross), 9 (circle), 10 (triangle), 11 (square), 12 (L1), 13 (R1), 14 (L2) and 15 (R2) clear byte-1 bits 6, 5, 4, 7, 2, 3, 0 and 1.
- R6: Input bits 31:16 have no effect on `pad_state` or on the record.
- R7: `pad_state` carries button byte 0 in bits [7:0], button byte 1 in bits [15:8], and zero in bits [31:16].
- R8: The record words are, in order: {byte0, 0x5A, 0x41, 0x00} (low byte 0x00); {0x80, 0x80, 0x80, byte1} (low byte byte1); 0x00000080; 0x00000000.
- R9: The record goes out lowest word first over four beats, and `out_last` is high only on the fourth beat.
- R10: While `out_valid` is high and `out_ready` is low, `out_valid`, `out_data` and `out_last` hold their values. The record uses the button bytes sampled in the cycle the request was accepted.
- R11: `send_req` is accepted only when no record is in flight; a request made while one is in flight is dropped and causes no further beats.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| hclk | input | 1 | Host clock |
| hrst_n | input | 1 | Host-domain reset, active low |
| host_wr_en | input | 1 | Write strobe for the input word |
| host_wr_data | input | 32 | Active-high controller input word |
| cclk | input | 1 | Core clock |
| crst_n | input | 1 | Core-domain reset, active low |
| pad_state | output | 32 | Synchronized button bytes, active low |
| send_req | input | 1 | Request to emit one response record |
| out_valid | output | 1 | Beat valid |
| out_ready | input | 1 | Beat accepted by the sink |
| out_data | output | 32 | Beat payload |
| out_last | output | 1 | Final beat of the record |

## Verification
The bench builds the block with its default widths: a 32-bit host word, a 16-bit button field and two synchronizer stages. With these values a walk of each of the sixteen button bits checks the whole remapping table, and the upper sixteen bits can be set to show they are ignored. The two-stage default also puts the domain-crossing latency inside a fixed four-cycle window. Back-pressure on `out_ready` is randomized, and requests arrive in the middle of a record, so the hold and drop rules are exercised at every beat position.

// File: rtl/pad_pkg.sv
package pad_pkg;

  localparam int BTN_W  = 16;
  localparam int BEAT_W = 32;
  localparam int BEATS  = 4;

  // Active-high input bits to active-low controller button bytes.
  function automatic logic [BTN_W-1:0] remap_buttons(input logic [BTN_W-1:0] w);
    logic [BTN_W-1:0] m;
    m = '0;
    m[5]  = w[0];   // right
    m[7]  = w[1];   // left
    m[6]  = w[2];   // down
    m[4]  = w[3];   // up
    m[3]  = w[4];   // start
    m[0]  = w[5];   // select
    m[1]  = w[6];   // L3
    m[2]  = w[7];   // R3
    m[14] = w[8];   // cross
    m[13] = w[9];   // circle
    m[12] = w[10];  // triangle
    m[15] = w[11];  // square
    m[10] = w[12];  // L1
    m[11] = w[13];  // R1
    m[8]  = w[14];  // L2
    m[9]  = w[15];  // R2
    return ~m;
  endfunction

  // One 32-bit word of the response record.
  function automatic logic [BEAT_W-1:0] record_word(input logic [1:0] idx,
                                                    input logic [BTN_W-1:0] btn);
    logic [BEAT_W-1:0] r;
    case (idx)
      2'd0:    r = {btn[7:0], 8'h5A, 8'h41, 8'h00};
      2'd1:    r = {8'h80, 8'h80, 8'h80, btn[15:8]};
      2'd2:    r = 32'h0000_0080;
      default: r = 32'h0000_0000;
    endcase
    return r;
  endfunction

endpackage

// File: rtl/pad_sync.sv
module pad_sync #(
  parameter int W      = 32,
  parameter int STAGES = 2
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] stg [STAGES];

  generate
    for (genvar i = 0; i < STAGES; i++) begin : g_stage
      if (i == 0) begin : g_first
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[0] <= '0;
          else        stg[0] <= d;
        end
      end else begin : g_next
        always_ff @(posedge clk or negedge rst_n) begin
          if (!rst_n) stg[i] <= '0;
          else        stg[i] <= stg[i-1];
        end
      end
    end
  endgenerate

  assign q = stg[STAGES-1];
endmodule

// File: rtl/pad_btn_map.sv
module pad_btn_map
  import pad_pkg::*;
(
  input  logic [BTN_W-1:0] raw,
  output logic [BTN_W-1:0] btn
);
  always_comb btn = remap_buttons(raw);
endmodule

// File: rtl/pad_packer.sv
module pad_packer
  import pad_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic [BTN_W-1:0]  btn,
  input  logic              send_req,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [BEAT_W-1:0] out_data,
  output logic              out_last,
  output logic              beat_fire,
  output logic              rec_start
);
  localparam int IDX_W = $clog2(BEATS);

  logic             busy;
  logic [IDX_W-1:0] idx;
  logic [BTN_W-1:0] snap;

  assign rec_start = send_req && !busy;
  assign beat_fire = busy && out_ready;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      busy <= 1'b0;
      idx  <= '0;
      snap <= '1;
    end else if (rec_start) begin
      busy <= 1'b1;
      idx  <= '0;
      snap <= btn;
    end else if (beat_fire) begin
      if (idx == IDX_W'(BEATS-1)) begin
        busy <= 1'b0;
        idx  <= '0;
      end else begin
        idx <= idx + 1'b1;
      end
    end
  end

  assign out_valid = busy;
  assign out_data  = busy ? record_word(2'(idx), snap) : '0;
  assign out_last  = busy && (idx == IDX_W'(BEATS-1));
endmodule

// File: rtl/pad_capture_packer.sv
module pad_capture_packer
  import pad_pkg::*;
#(
  parameter int WORD_W      = 32,
  parameter int SYNC_STAGES = 2
) (
  input  logic              hclk,
  input  logic              hrst_n,
  input  logic              host_wr_en,
  input  logic [WORD_W-1:0] host_wr_data,
  input  logic              cclk,
  input  logic              crst_n,
  output logic [31:0]       pad_state,
  input  logic              send_req,
  output logic              out_valid,
  input  logic              out_ready,
  output logic [31:0]       out_data,
  output logic              out_last
);
  logic [BTN_W-1:0] host_q;
  logic [BTN_W-1:0] core_raw;
  logic [BTN_W-1:0] core_btn;
  logic             beat_fire;
  logic             rec_start;

  // Only the button field is held; upper bits of the word are dropped.
  always_ff @(posedge hclk or negedge hrst_n) begin
    if (!hrst_n)         host_q <= '0;
    else if (host_wr_en) host_q <= host_wr_data[BTN_W-1:0];
  end

  pad_sync #(.W(BTN_W), .STAGES(SYNC_STAGES)) u_sync (
    .clk(cclk), .rst_n(crst_n), .d(host_q), .q(core_raw)
  );

  pad_btn_map u_map (.raw(core_raw), .btn(core_btn));

  assign pad_state = {{(32-BTN_W){1'b0}}, core_btn};

  pad_packer u_pack (
    .clk(cclk), .rst_n(crst_n), .btn(core_btn), .send_req(send_req),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
    .out_last(out_last), .beat_fire(beat_fire), .rec_start(rec_start)
  );
endmodule

// File: rtl/pad_capture_packer_chk.sv
module pad_capture_packer_chk (
  input logic        cclk,
  input logic        crst_n,
  input logic [31:0] pad_state,
  input logic        out_valid,
  input logic        out_ready,
  input logic [31:0] out_data,
  input logic        out_last,
  input logic        beat_fire,
  input logic        rec_start
);
  logic [1:0] seen;

  always_ff @(posedge cclk or negedge crst_n) begin
    if (!crst_n)        seen <= '0;
    else if (beat_fire) seen <= seen + 2'd1;
  end

  a_r7_upper_zero: assert property (@(posedge cclk) disable iff (!crst_n)
    pad_state[31:16] == 16'h0);

  a_r10_hold: assert property (@(posedge cclk) disable iff (!crst_n)
    out_valid && !out_ready |=> out_valid && $stable(out_data) && $stable(out_last));

  a_r9_last_pos: assert property (@(posedge cclk) disable iff (!crst_n)
    out_valid |-> (out_last == (seen == 2'd3)));

  a_r8_header: assert property (@(posedge cclk) disable iff (!crst_n)
    out_valid && seen == 2'd0 |-> out_data[23:0] == 24'h5A4100);

  a_r8_tail: assert property (@(posedge cclk) disable iff (!crst_n)
    out_valid && seen == 2'd3 |-> out_data == 32'h0);

  a_r11_continue: assert property (@(posedge cclk) disable iff (!crst_n)
    out_valid && !(beat_fire && out_last) |=> out_valid);

  a_r11_no_restart: assert property (@(posedge cclk) disable iff (!crst_n)
    out_valid |-> !rec_start);
endmodule

bind pad_capture_packer pad_capture_packer_chk u_chk (
  .cclk(cclk), .crst_n(crst_n), .pad_state(pad_state), .out_valid(out_valid),
  .out_ready(out_ready), .out_data(out_data), .out_last(out_last),
  .beat_fire(beat_fire), .rec_start(rec_start)
);

// File: tb/pad_capture_packer_tb.sv
`timescale 1ns/1ps
module pad_capture_packer_tb;
  logic hclk = 0, cclk = 0;
  logic hrst_n = 0, crst_n = 0;
  logic host_wr_en = 0;
  logic [31:0] host_wr_data = 0;
  logic [31:0] pad_state;
  logic send_req = 0;
  logic out_valid, out_ready, out_last;
  logic [31:0] out_data;

  always #2 hclk = ~hclk;
  always #4 cclk = ~cclk;   // 125 MHz core clock

  pad_capture_packer u_dut (
    .hclk(hclk), .hrst_n(hrst_n), .host_wr_en(host_wr_en), .host_wr_data(host_wr_data),
    .cclk(cclk), .crst_n(crst_n), .pad_state(pad_state), .send_req(send_req),
    .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data), .out_last(out_last)
  );

  int total = 0, failed = 0;
  int dst [16] = '{5, 7, 6, 4, 3, 0, 1, 2, 14, 13, 12, 15, 10, 11, 8, 9};
  logic [15:0] mdl_pad = 16'hFFFF;
  bit settled = 1;
  logic [31:0] q[$];
  int beats_seen = 0;
  int ready_mode = 0;
  logic [15:0] lfsr = 16'hACE1;

  function automatic logic [15:0] expect_pad(input logic [31:0] w);
    logic [15:0] r = 16'hFFFF;
    for (int i = 0; i < 16; i++) if (w[i]) r[dst[i]] = 1'b0;
    return r;
  endfunction

  task automatic check(input string req, input logic [31:0] got, input logic [31:0] exp);
    total++;
    if (got !== exp) begin
      failed++;
      $display("FAIL %s got 0x%08h expected 0x%08h", req, got, exp);
    end
  endtask

  // Reference model and per-cycle comparison.
  always @(negedge cclk) begin
    logic [7:0] by [16];
    bit was_busy;
    check("R9/R11 valid", {31'd0, out_valid}, {31'd0, q.size() > 0});
    if (q.size() > 0) begin
      check("R8/R10 data", out_data, q[0]);
      check("R9 last", {31'd0, out_last}, {31'd0, q.size() == 1});
    end
    if (settled && crst_n) check("R7 pad_state", pad_state, {16'h0, mdl_pad});
    if (!crst_n) q.delete();
    else begin
      was_busy = q.size() > 0;
      if (was_busy && out_ready) begin void'(q.pop_front()); beats_seen++; end
      if (!was_busy && send_req) begin
        foreach (by[k]) by[k] = 8'h00;
        by[1] = 8'h41; by[2] = 8'h5A; by[3] = mdl_pad[7:0]; by[4] = mdl_pad[15:8];
        by[5] = 8'h80; by[6] = 8'h80; by[7] = 8'h80; by[8] = 8'h80;
        for (int w = 0; w < 4; w++) q.push_back({by[4*w+3], by[4*w+2], by[4*w+1], by[4*w]});
      end
    end
  end

  always @(posedge cclk) begin
    #1;
    lfsr <= {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    out_ready <= (ready_mode == 0) ? 1'b1 : lfsr[0];
  end

  task automatic cyc(input int n);
    repeat (n) @(posedge cclk);
    #1;
  endtask

  task automatic host_write(input logic [31:0] w);
    settled = 0;
    @(posedge hclk); #1; host_wr_en = 1; host_wr_data = w;
    @(posedge hclk); #1; host_wr_en = 0;
    mdl_pad = expect_pad(w);
  endtask

  task automatic send_record(input bit spam);
    cyc(1); send_req = 1;
    cyc(1); send_req = spam;
    repeat (40) begin
      cyc(1);
      if (q.size() == 0) break;
    end
    send_req = 0;
    cyc(2);
  endtask

  task automatic run();
    int b;
    cyc(3);
    check("R1 reset pad_state", pad_state, 32'h0000FFFF);
    check("R1 reset valid", {31'd0, out_valid}, 32'd0);
    hrst_n = 1; crst_n = 1;
    cyc(2);
    check("R3 idle bytes", pad_state, 32'h0000FFFF);
    send_record(0);
    check("R9 idle record beats", beats_seen, 4);
    host_write(32'h1); cyc(4); settled = 1;
    check("R2/R4 right", pad_state, 32'h0000FFDF);
    host_write(32'h21); cyc(4); settled = 1;
    check("R4 right+select", pad_state, 32'h0000FFDE);
    ready_mode = 1;
    b = beats_seen;
    send_record(0);
    check("R9 four beats", beats_seen - b, 4);
    for (int i = 0; i < 16; i++) begin
      host_write(32'h1 << i); cyc(4); settled = 1;
      check("R5 bit map", pad_state, {16'h0, expect_pad(32'h1 << i)});
    end
    host_write(32'hFFFF_0000); cyc(4); settled = 1;
    check("R6 upper ignored", pad_state, 32'h0000FFFF);
    b = beats_seen;
    send_record(0);
    check("R6 record after upper bits", beats_seen - b, 4);
    host_write(32'h0000_A5C3); cyc(4); settled = 1;
    b = beats_seen;
    send_record(1);
    check("R11 spam gives whole records", (beats_seen - b) % 4, 0);
    check("R11 idle after", {31'd0, out_valid}, 32'd0);
    ready_mode = 0;
    host_write(32'h0); cyc(4); settled = 1;
    check("R3 re-clear", pad_state, 32'h0000FFFF);
    send_record(0);
  endtask

  initial begin
    out_ready = 1;
    fork
      run();
      begin
        repeat (20000) @(posedge cclk);
        total++; failed++;
        $display("FAIL watchdog got timeout expected completion");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", total - failed, total);
    $finish;
  end
endmodule